// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block moves 32-bit values between the lanes of a SIMD warp in a single registered step. Every lane presents one source word. A mode, a shared delta operand and an active-lane mask apply to all lanes at once. Each lane then works out which lane to read from, and a full crossbar delivers that lane's word.

The warp can be cut into equal tiles of `TILE` lanes. No exchange crosses a tile edge. Shift patterns that would leave the tile return the lane's own word. The butterfly and indexed patterns wrap inside the tile.

The result is registered. `out_valid` follows `in_valid` one cycle later. A new operation can be accepted every cycle, with no stall.

Top module: `warp_shuffle`

## Requirements
- R1: Mode 0 (up) makes lane i take the word of lane i-delta. If that lane lies below the base of lane i's tile, lane i keeps its own word.
- R2: Mode 1 (down) makes lane i take the word of lane i+delta. If that lane lies at or past the end of lane i's tile, lane i keeps its own word.
- R3: Mode 2 (butterfly) makes lane i take the word of the lane whose in-tile offset is (offset of i) XOR delta, kept within lane i's tile.
- R4: Mode 3 (indexed) makes lane i take the word of lane tile_base + (delta mod TILE).
- R5: If the selected source lane has its mask bit clear, lane i returns its own word. A mask of all zeros therefore passes every word through unchanged.
- R6: Tiles are TILE lanes wide and aligned to multiples of TILE. No lane ever receives a word from another tile.
- R7: A delta of 0 in modes up, down and butterfly returns every lane's own word.
- R8: `out_valid` is `in_valid` delayed by exactly one clock. Back-to-back operations are each accepted and produce results on consecutive cycles.
- R9: While `in_valid` is low, `out_data` holds the last result.
- R10: During reset, `out_valid` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_mode | input | 2 | 0 up, 1 down, 2 butterfly, 3 indexed |
| in_delta | input | $clog2(LANES) | Shared offset or index operand |
| in_mask | input | LANES | Active-lane mask, bit i for lane i |
| in_data | input | LANES*DW | Source words, lane i at bits [i*DW +: DW] |
| out_valid | output | 1 | Result valid |
| out_data | output | LANES*DW | Exchanged words, lane i at bits [i*DW +: DW] |

## Verification
The hardest cases to reach are those where two rules meet at a tile edge. Examples are a shift that lands exactly on the edge, and a butterfly or indexed source that is masked off while the lane's own mask bit is set.

The bench builds the unit with tiles narrower than the warp. It sweeps delta across every value, including values larger than the tile, for each mode. It pairs these with sparse, dense and empty masks, so edge and masked sources occur in the same operation.

The operations are issued back to back, and after gaps. This lets the scoreboard also check the exact one-cycle latency and the hold of the output.

// File: rtl/shfl_pkg.sv
package shfl_pkg;
  typedef enum logic [1:0] {
    SHFL_UP   = 2'd0,
    SHFL_DOWN = 2'd1,
    SHFL_XOR  = 2'd2,
    SHFL_IDX  = 2'd3
  } shfl_mode_e;
endpackage

// File: rtl/shfl_src_sel.sv
// Per-lane source index computation for one fixed lane.
module shfl_src_sel
  import shfl_pkg::*;
#(
  parameter int LANES = 8,
  parameter int TILE  = 8,
  parameter int LANE  = 0,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [1:0]       mode,
  input  logic [LW-1:0]    delta,
  input  logic [LANES-1:0] mask,
  output logic [LW-1:0]    src
);
  localparam int BASE = (LANE / TILE) * TILE;
  localparam int OFS  = LANE % TILE;

  int d_i;
  int cand;

  always_comb begin
    d_i = int'(delta);
    case (shfl_mode_e'(mode))
      SHFL_UP:   cand = (d_i <= OFS) ? (LANE - d_i) : LANE;
      SHFL_DOWN: cand = ((OFS + d_i) < TILE) ? (LANE + d_i) : LANE;
      SHFL_XOR:  cand = BASE + ((OFS ^ d_i) % TILE);
      default:   cand = BASE + (d_i % TILE);
    endcase
    // Inactive source lane: fall back to own word
    src = mask[LW'(cand)] ? LW'(cand) : LW'(LANE);
  end
endmodule

// File: rtl/shfl_xbar.sv
// Full LANES x LANES word crossbar.
module shfl_xbar #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] src_data,
  input  logic [LANES*LW-1:0] sel,
  output logic [LANES*DW-1:0] dst_data
);
  logic [DW-1:0] word_a [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_a[g] = src_data[g*DW +: DW];
    assign dst_data[g*DW +: DW] = word_a[sel[g*LW +: LW]];
  end
endmodule

// File: rtl/warp_shuffle.sv
module warp_shuffle #(
  parameter int LANES = 8,
  parameter int TILE  = 8,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          in_mode,
  input  logic [LW-1:0]       in_delta,
  input  logic [LANES-1:0]    in_mask,
  input  logic [LANES*DW-1:0] in_data,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data
);
  logic [LANES*LW-1:0] sel;
  logic [LANES*DW-1:0] xbar_out;
  logic [LANES*DW-1:0] data_d, data_q;
  logic                vld_d, vld_q;

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    shfl_src_sel #(.LANES(LANES), .TILE(TILE), .LANE(g)) u_sel (
      .mode  (in_mode),
      .delta (in_delta),
      .mask  (in_mask),
      .src   (sel[g*LW +: LW])
    );
  end

  shfl_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
    .src_data (in_data),
    .sel      (sel),
    .dst_data (xbar_out)
  );

  always_comb begin
    vld_d  = in_valid;
    data_d = in_valid ? xbar_out : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_d;
      data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/shfl_checker.sv
module shfl_checker #(
  parameter int LANES = 8,
  parameter int TILE  = 8,
  parameter int DW    = 32,
  localparam int LW   = $clog2(LANES)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          in_mode,
  input logic [LW-1:0]       in_delta,
  input logic [LANES-1:0]    in_mask,
  input logic [LANES*DW-1:0] in_data,
  input logic                out_valid,
  input logic [LANES*DW-1:0] out_data
);
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid) else $error("valid latency");               // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid) else $error("spurious valid");            // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)) else $error("data not held");      // R9
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mask == '0) |=> out_data == $past(in_data))
    else $error("empty mask");                                          // R5
  AST_ZERO_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_delta == '0 && in_mode != 2'd3) |=> out_data == $past(in_data))
    else $error("zero delta");                                          // R7
  AST_IDX_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd3 && (&in_mask)) |=>
      out_data[0 +: DW] == out_data[(TILE-1)*DW +: DW])
    else $error("indexed broadcast");                                   // R4
endmodule

bind warp_shuffle shfl_checker #(.LANES(LANES), .TILE(TILE), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
  .in_delta(in_delta), .in_mask(in_mask), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/warp_shuffle_test.sv
module warp_shuffle_test;
  localparam int LANES = 8;
  localparam int TILE  = 4;
  localparam int DW    = 32;
  localparam int LW    = $clog2(LANES);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic [1:0]          in_mode = '0;
  logic [LW-1:0]       in_delta = '0;
  logic [LANES-1:0]    in_mask = '0;
  logic [LANES*DW-1:0] in_data = '0;
  logic                out_valid;
  logic [LANES*DW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  bit seen   = 0;
  int pushed = 0;
  int popped = 0;
  logic [LANES*DW-1:0] last_exp = '0;

  logic [LANES*DW-1:0] q_data [$];
  string               q_tag  [$];
  int                  q_cyc  [$];

  warp_shuffle #(.LANES(LANES), .TILE(TILE), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_delta(in_delta), .in_mask(in_mask), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int src_of(int mode, int d, logic [LANES-1:0] m, int i);
    int base = (i / TILE) * TILE;
    int o = i % TILE;
    int s;
    case (mode)
      0: s = (d <= o) ? i - d : i;
      1: s = (o + d < TILE) ? i + d : i;
      2: s = base + ((o ^ d) % TILE);
      default: s = base + (d % TILE);
    endcase
    return m[s] ? s : i;
  endfunction

  function automatic logic [LANES*DW-1:0] model(int mode, int d,
      logic [LANES-1:0] m, logic [LANES*DW-1:0] x);
    logic [LANES*DW-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*DW +: DW] = x[src_of(mode, d, m, i)*DW +: DW];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [LANES*DW-1:0] act,
                       logic [LANES*DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(int mode, int d, logic [LANES-1:0] m, string tag);
    logic [LANES*DW-1:0] x;
    for (int i = 0; i < LANES; i++) x[i*DW +: DW] = $urandom;
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'(mode); in_delta = LW'(d);
    in_mask = m; in_data = x;
    q_data.push_back(model(mode, d, m, x));
    q_tag.push_back(tag);
    q_cyc.push_back(cyc);
    pushed++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_data.size() == 0) begin
          check(0, "R8 unexpected out_valid", out_data, '0);
        end else begin
          logic [LANES*DW-1:0] e;
          string t;
          int c;
          e = q_data.pop_front(); t = q_tag.pop_front(); c = q_cyc.pop_front();
          popped++;
          check(out_data == e, t, out_data, e);
          check(cyc - c == 1, "R8 latency", LANES*DW'(cyc - c), LANES*DW'(1));
          last_exp = e;
          seen = 1;
        end
      end else if (seen) begin
        check(out_data == last_exp, "R9 hold while idle", out_data, last_exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 reset valid", {LANES*DW{out_valid}}, '0);
    check(out_data == '0, "R10 reset data", out_data, '0);
    rst_n = 1'b1;
    idle(2);
    for (int d = 0; d < LANES; d++) send(0, d, '1, "R1 up full mask");
    for (int d = 0; d < LANES; d++) send(1, d, '1, "R2 down full mask");
    idle(2);
    for (int d = 0; d < LANES; d++) send(2, d, '1, "R3 butterfly full mask");
    for (int d = 0; d < LANES; d++) send(3, d, '1, "R4 indexed, delta beyond tile wraps");
    idle(3);
    send(0, 0, 8'hA5, "R7 zero delta up");
    send(1, 0, 8'h3C, "R7 zero delta down");
    send(2, 0, 8'hFF, "R7 zero delta butterfly");
    for (int mo = 0; mo < 4; mo++) send(mo, 2, '0, "R5 empty mask passthrough");
    for (int mo = 0; mo < 4; mo++)
      for (int d = 1; d < LANES; d++) send(mo, d, 8'b0110_1001, "R5 sparse mask");
    idle(1);
    for (int k = 0; k < 40; k++)
      send(int'($urandom % 4), int'($urandom % LANES), LANES'($urandom),
           "R6 random tile-confined exchange");
    idle(4);
    done = 1;
    check(popped == pushed, "R8 result count",
          LANES*DW'(popped), LANES*DW'(pushed));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule